// File: doc/BRIEF.md
# Fully Associative TLB Match Unit

This block holds a small, parameterised set of address translation entries for a 64-bit MMU whose refills are done by software. Each entry maps an aligned pair of virtual pages, even and odd, onto two physical frames. It stores a virtual page-pair number, a page-size mask, an address-space identifier (ASID), a global flag, and a frame number with a valid bit for each half.

Software loads one entry at a time through the write port. It supplies an index, an entry-high word (virtual page and ASID), a page-mask field and two entry-low words, one per half. The lookup port is purely combinational. It takes a virtual address and the current ASID and returns a hit flag, the index of the winning entry, the frame and valid bit of the selected half, and a flag set when more than one entry matched. A hit whose half is not valid is reported as a hit with valid low, so the caller can tell an invalid-page fault apart from a refill miss.

Top module: `tlb_match`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every entry holds VPN 0, mask 0, ASID 0, global 0 and both valid bits 0.
- R2: A write with `wr_en_i` high updates entry `wr_idx_i` on the rising clock edge. Before that edge, lookups still see the old contents. The stored ASID is `entryhi_i[7:0]`, the page-mask field is `pagemask_i`, and each entry-low word holds global in bit 0, valid in bit 1 and the frame in bits PFN_W+1:2.
- R3: The ignored bits of an entry are its page-mask field placed at bit 13 upward, ORed with bits 12:0. The address and the stored VPN must be equal on every bit that is not ignored.
- R4: Only address bits 63:62 and 39:0 take part in matching. Bits 61:40 of the lookup address and of `entryhi_i` have no effect.
- R5: A VPN match counts as a hit only if the entry is global or its ASID equals `lk_asid_i`. An entry is global only when bit 0 of both entry-low words was set at write time.
- R6: The highest ignored bit selects the half. When the address has a 0 there, the even half (entry-low 0) is used. When it has a 1, the odd half (entry-low 1) is used.
- R7: A hit on a half whose valid bit is clear gives `hit_o`=1, `valid_o`=0, and still returns that half's frame.
- R8: When several entries hit, `idx_o` is the lowest hitting index and `multi_o` is 1. With one hit, `multi_o` is 0.
- R9: On a miss, `hit_o`, `valid_o`, `frame_o`, `idx_o` and `multi_o` are all zero.
- R10: The lookup outputs follow `lk_va_i` and `lk_asid_i` combinationally. With no write, the outputs change only when those inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load one entry at the next edge |
| wr_idx_i | input | $clog2(N_ENTRIES) | Entry to load |
| entryhi_i | input | 64 | Virtual page-pair number and ASID (bits 7:0) |
| pagemask_i | input | PM_W | Page-size mask, covering address bits 13 upward |
| entrylo0_i | input | PFN_W+2 | Even half: global, valid, frame |
| entrylo1_i | input | PFN_W+2 | Odd half: global, valid, frame |
| lk_va_i | input | 64 | Lookup virtual address |
| lk_asid_i | input | ASID_W | Current ASID |
| hit_o | output | 1 | At least one entry matched |
| valid_o | output | 1 | Selected half is valid |
| frame_o | output | PFN_W | Frame of the selected half |
| idx_o | output | $clog2(N_ENTRIES) | Lowest matching entry |
| multi_o | output | 1 | More than one entry matched |

## Verification
The properties assume at most one write per cycle. They also assume that a lookup address equal to the entry-high word just written, presented with that word's ASID, must hit. This holds only because the written VPN is compared against the address under the same mask.

The stimulus loads page masks that are contiguous runs of ones starting at bit 13. It then probes each entry at both ends of both halves and with junk in the ignored high bits. It also flips kept bits, swaps the ASID, and makes two entries overlap, all in a configuration small enough that the bench model covers every entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VaW = 64;
  typedef logic [VaW-1:0] va_t;

  // bits that survive tag comparison: the two region bits and the low seg_w bits
  function automatic va_t keep_mask(int seg_w);
    va_t m;
    m = '0;
    for (int b = 0; b < VaW; b++) begin
      if (b < seg_w || b >= VaW - 2) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 24,
  parameter int PM_W      = 16,
  parameter int PAIR_LSB  = 13,
  parameter int SEG_W     = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  va_t                  entryhi_i,
  input  logic [PM_W-1:0]      pagemask_i,
  input  logic [PFN_W+1:0]     entrylo0_i,
  input  logic [PFN_W+1:0]     entrylo1_i,
  output va_t                  vpn_o   [N_ENTRIES],
  output logic [PM_W-1:0]      pm_o    [N_ENTRIES],
  output logic [ASID_W-1:0]    asid_o  [N_ENTRIES],
  output logic [PFN_W-1:0]     pfn0_o  [N_ENTRIES],
  output logic [PFN_W-1:0]     pfn1_o  [N_ENTRIES],
  output logic [N_ENTRIES-1:0] glob_o,
  output logic [N_ENTRIES-1:0] v0_o,
  output logic [N_ENTRIES-1:0] v1_o
);
  localparam va_t KeepMsk = keep_mask(SEG_W);
  localparam va_t PairMsk = ~va_t'((64'd1 << PAIR_LSB) - 64'd1);

  va_t vpn_wr;
  assign vpn_wr = entryhi_i & PairMsk & KeepMsk;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_o[i]  <= '0;
        pm_o[i]   <= '0;
        asid_o[i] <= '0;
        pfn0_o[i] <= '0;
        pfn1_o[i] <= '0;
        glob_o[i] <= 1'b0;
        v0_o[i]   <= 1'b0;
        v1_o[i]   <= 1'b0;
      end else if (sel) begin
        vpn_o[i]  <= vpn_wr;
        pm_o[i]   <= pagemask_i;
        asid_o[i] <= entryhi_i[ASID_W-1:0];
        pfn0_o[i] <= entrylo0_i[PFN_W+1:2];
        pfn1_o[i] <= entrylo1_i[PFN_W+1:2];
        glob_o[i] <= entrylo0_i[0] & entrylo1_i[0];
        v0_o[i]   <= entrylo0_i[1];
        v1_o[i]   <= entrylo1_i[1];
      end
    end
  end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
#(
  parameter int ASID_W   = 8,
  parameter int PM_W     = 16,
  parameter int PAIR_LSB = 13,
  parameter int SEG_W    = 40
) (
  input  va_t               va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  va_t               vpn_i,
  input  logic [PM_W-1:0]   pm_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic              glob_i,
  output logic              match_o,
  output logic              odd_o
);
  localparam va_t KeepMsk = keep_mask(SEG_W);

  va_t ign, sel_bit, tag, ref_tag;

  assign ign     = {{(VaW-PM_W-PAIR_LSB){1'b0}}, pm_i, {PAIR_LSB{1'b1}}};
  assign tag     = va_i  & ~ign & KeepMsk;
  assign ref_tag = vpn_i & ~ign & KeepMsk;
  // top bit of the ignored run picks even/odd
  assign sel_bit = ign & ~(ign >> 1);

  assign match_o = (tag == ref_tag) && (glob_i || (ent_asid_i == asid_i));
  assign odd_o   = |(va_i & sel_bit);
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [N_ENTRIES-1:0] match_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |match_i;
  assign multi_o = |(match_i & (match_i - N_ENTRIES'(1)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 24,
  parameter int PM_W      = 16,
  parameter int PAIR_LSB  = 13,
  parameter int SEG_W     = 40,
  localparam int IdxW     = $clog2(N_ENTRIES),
  localparam int LoW      = PFN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IdxW-1:0]   wr_idx_i,
  input  logic [63:0]       entryhi_i,
  input  logic [PM_W-1:0]   pagemask_i,
  input  logic [LoW-1:0]    entrylo0_i,
  input  logic [LoW-1:0]    entrylo1_i,
  input  logic [63:0]       lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [PFN_W-1:0]  frame_o,
  output logic [IdxW-1:0]   idx_o,
  output logic              multi_o
);
  va_t                  vpn  [N_ENTRIES];
  logic [PM_W-1:0]      pm   [N_ENTRIES];
  logic [ASID_W-1:0]    asid [N_ENTRIES];
  logic [PFN_W-1:0]     pfn0 [N_ENTRIES];
  logic [PFN_W-1:0]     pfn1 [N_ENTRIES];
  logic [N_ENTRIES-1:0] glob, v0, v1, match, odd;

  tlb_store #(
    .N_ENTRIES(N_ENTRIES), .IDX_W(IdxW), .ASID_W(ASID_W), .PFN_W(PFN_W),
    .PM_W(PM_W), .PAIR_LSB(PAIR_LSB), .SEG_W(SEG_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .entryhi_i  (entryhi_i),
    .pagemask_i (pagemask_i),
    .entrylo0_i (entrylo0_i),
    .entrylo1_i (entrylo1_i),
    .vpn_o      (vpn),
    .pm_o       (pm),
    .asid_o     (asid),
    .pfn0_o     (pfn0),
    .pfn1_o     (pfn1),
    .glob_o     (glob),
    .v0_o       (v0),
    .v1_o       (v1)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    tlb_entry_cmp #(
      .ASID_W(ASID_W), .PM_W(PM_W), .PAIR_LSB(PAIR_LSB), .SEG_W(SEG_W)
    ) u_cmp (
      .va_i       (lk_va_i),
      .asid_i     (lk_asid_i),
      .vpn_i      (vpn[i]),
      .pm_i       (pm[i]),
      .ent_asid_i (asid[i]),
      .glob_i     (glob[i]),
      .match_o    (match[i]),
      .odd_o      (odd[i])
    );
  end

  logic            any;
  logic [IdxW-1:0] win;

  tlb_prio_sel #(.N_ENTRIES(N_ENTRIES), .IDX_W(IdxW)) u_prio (
    .match_i (match),
    .any_o   (any),
    .idx_o   (win),
    .multi_o (multi_o)
  );

  logic win_odd;
  assign win_odd = odd[win];

  assign hit_o   = any;
  assign idx_o   = win;
  assign valid_o = any && (win_odd ? v1[win] : v0[win]);
  assign frame_o = any ? (win_odd ? pfn1[win] : pfn0[win]) : '0;
endmodule

// File: rtl/tlb_match_chk.sv
module tlb_match_chk #(
  parameter int N_ENTRIES = 8,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 24,
  localparam int IdxW     = $clog2(N_ENTRIES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [63:0]       entryhi_i,
  input logic [63:0]       lk_va_i,
  input logic [ASID_W-1:0] lk_asid_i,
  input logic              hit_o,
  input logic              valid_o,
  input logic [PFN_W-1:0]  frame_o,
  input logic [IdxW-1:0]   idx_o,
  input logic              multi_o
);
  // R9: a miss leaves every lookup output at zero
  p_miss_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!valid_o && frame_o == '0 && idx_o == '0 && !multi_o));

  // R7: valid only ever accompanies a hit
  p_valid_needs_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> hit_o);

  // R8: multiple match implies a hit
  p_multi_needs_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  // R2: the entry-high just written, with its ASID, hits on the following cycle
  p_write_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && lk_va_i == $past(entryhi_i) &&
     lk_asid_i == $past(entryhi_i[ASID_W-1:0])) |-> hit_o);

  // R10: with no write and steady lookup inputs, outputs hold
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $stable(lk_va_i) && $stable(lk_asid_i)) |->
      ($stable(hit_o) && $stable(idx_o) && $stable(frame_o) &&
       $stable(valid_o) && $stable(multi_o)));
endmodule

bind tlb_match tlb_match_chk #(
  .N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W), .PFN_W(PFN_W)
) u_chk (.*);

// File: tb/tb_tlb_match.sv
module tb_tlb_match;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 24;
  localparam int MW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_idx_i = '0;
  logic [63:0]   entryhi_i = '0;
  logic [MW-1:0] pagemask_i = '0;
  logic [PW+1:0] entrylo0_i = '0, entrylo1_i = '0;
  logic [63:0]   lk_va_i = '0;
  logic [7:0]    lk_asid_i = '0;
  logic          hit_o, valid_o, multi_o;
  logic [PW-1:0] frame_o;
  logic [2:0]    idx_o;

  tlb_match dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [63:0]   m_hi  [N];
  logic [MW-1:0] m_pm  [N];
  logic [PW+1:0] m_lo0 [N], m_lo1 [N];

  localparam logic [63:0] KEEP = 64'hC000_00FF_FFFF_FFFF;

  function automatic logic [63:0] ign_of(input logic [MW-1:0] pm);
    return (64'(pm) << 13) | 64'h1FFF;
  endfunction

  task automatic model(input logic [63:0] va, input logic [7:0] asid,
                       output logic e_hit, output logic e_val,
                       output logic [PW-1:0] e_fr, output logic [2:0] e_idx,
                       output logic e_mul);
    int cnt = 0;
    e_hit = 0; e_val = 0; e_fr = '0; e_idx = '0; e_mul = 0;
    for (int i = 0; i < N; i++) begin
      logic [63:0] ig, sb;
      logic g, odd;
      ig  = ign_of(m_pm[i]);
      g   = m_lo0[i][0] & m_lo1[i][0];
      if ((((va ^ m_hi[i]) & ~ig & KEEP) == 64'd0) && (g || m_hi[i][7:0] == asid)) begin
        if (cnt == 0) begin
          sb  = ig & ~(ig >> 1);
          odd = |(va & sb);
          e_hit = 1;
          e_idx = 3'(i);
          e_val = odd ? m_lo1[i][1] : m_lo0[i][1];
          e_fr  = odd ? m_lo1[i][PW+1:2] : m_lo0[i][PW+1:2];
        end
        cnt++;
      end
    end
    e_mul = (cnt > 1);
  endtask

  task automatic compare(input string tag);
    logic e_hit, e_val, e_mul;
    logic [PW-1:0] e_fr;
    logic [2:0] e_idx;
    model(lk_va_i, lk_asid_i, e_hit, e_val, e_fr, e_idx, e_mul);
    n_chk++;
    if (hit_o !== e_hit || valid_o !== e_val || frame_o !== e_fr ||
        idx_o !== e_idx || multi_o !== e_mul) begin
      n_bad++;
      $display("FAIL %s va=%h asid=%h actual hit=%b val=%b fr=%h idx=%0d mul=%b expected hit=%b val=%b fr=%h idx=%0d mul=%b",
               tag, lk_va_i, lk_asid_i, hit_o, valid_o, frame_o, idx_o, multi_o,
               e_hit, e_val, e_fr, e_idx, e_mul);
    end
  endtask

  task automatic probe(input logic [63:0] va, input logic [7:0] asid, input string tag);
    @(negedge clk_i);
    lk_va_i = va; lk_asid_i = asid;
    #2;
    compare(tag);
  endtask

  task automatic do_write(input int idx, input logic [63:0] hi, input logic [MW-1:0] pm,
                          input logic [PW+1:0] lo0, input logic [PW+1:0] lo1);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 3'(idx); entryhi_i = hi; pagemask_i = pm;
    entrylo0_i = lo0; entrylo1_i = lo1;
    lk_va_i = hi; lk_asid_i = hi[7:0];
    #2;
    compare("R2 before edge");
    @(posedge clk_i);
    m_hi[idx] = hi; m_pm[idx] = pm; m_lo0[idx] = lo0; m_lo1[idx] = lo1;
    #2;
    compare("R2 after edge");
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic sweep(input int i);
    logic [63:0] ig, sb, base;
    logic [63:0] offs [6];
    ig   = ign_of(m_pm[i]);
    sb   = ig & ~(ig >> 1);
    base = m_hi[i] & ~ig;
    offs[0] = 64'd0; offs[1] = sb; offs[2] = sb - 64'd1; offs[3] = ig;
    offs[4] = 64'h345 & ig; offs[5] = (sb | 64'h1000) & ig;
    for (int o = 0; o < 6; o++) begin
      for (int v = 0; v < 4; v++) begin
        for (int a = 0; a < 2; a++) begin
          logic [63:0] va;
          logic [7:0] as;
          string t;
          va = base | offs[o];
          as = (a == 0) ? m_hi[i][7:0] : (m_hi[i][7:0] ^ 8'h40);
          case (v)
            0: t = (a == 0) ? "R3 R6 R7" : "R5 asid";
            1: begin va = va ^ 64'h3FFF_FF00_0000_0000; t = "R4 ignored bits"; end
            2: begin va = va ^ (64'd1 << 39); t = "R4 R9 kept bit 39"; end
            default: begin va = va ^ (64'd1 << 62); t = "R4 R9 kept bit 62"; end
          endcase
          probe(va, as, t);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_hi[i] = '0; m_pm[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    #3;
    lk_va_i = 64'd0; lk_asid_i = 8'd0;
    #1;
    compare("R1 during reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    probe(64'd0, 8'd1, "R1 R9 reset miss");
    probe(64'd0, 8'd0, "R1 R7 R8 reset all-zero entries");

    for (int i = 0; i < N; i++) begin
      logic [63:0] hi;
      logic [MW-1:0] pm;
      logic [PW+1:0] lo0, lo1;
      int k;
      k  = i % 4;
      hi = (64'(i & 3) << 62) | 64'h2A5A_5A00_0000_0000 | (64'(i + 1) << 32) |
           (64'(i * 7) << 13) | 64'(8'(i + 3));
      pm = MW'((1 << (2 * k)) - 1);
      lo0 = {PW'(24'hA00 + i), 1'b1, (i == 5 || i == 6) ? 1'b1 : 1'b0};
      lo1 = {PW'(24'hB00 + i), (i % 2 == 0) ? 1'b1 : 1'b0, (i == 5) ? 1'b1 : 1'b0};
      do_write(i, hi, pm, lo0, lo1);
    end

    for (int i = 0; i < N; i++) sweep(i);

    // R10: two lookups within one low phase, no clock edge between them
    @(negedge clk_i);
    lk_va_i = m_hi[3]; lk_asid_i = m_hi[3][7:0];
    #1; compare("R10 comb a");
    lk_va_i = m_hi[4]; lk_asid_i = m_hi[4][7:0];
    #1; compare("R10 comb b");

    // R8: overlap entry 7 onto entry 2
    do_write(7, m_hi[2], m_pm[2], {PW'(24'hC07), 2'b10}, {PW'(24'hD07), 2'b10});
    sweep(2);
    sweep(7);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule